// File: doc/BRIEF.md
# Event Timer Global Register Block

This block is the shared front end of a multi-channel event timer. It decodes a 1 KiB register window that a simple single-cycle register bus reaches with 32-bit words. It holds the read-only capability word, the global configuration (overall enable and legacy-routing select) and the per-channel interrupt-status bits, and it runs the 64-bit main counter that every channel compares against.

The main counter advances by one on each cycle where the tick strobe is high and the block is enabled. Clearing the enable bit freezes the count, and setting it again resumes counting from the frozen value. Each 64-bit register is reached as two 32-bit halves, and address bit 2 selects the upper half. Accesses that fall in a channel's register group are decoded and forwarded to that channel as a one-hot select, a register code and a half select. For those accesses the channel's read word is returned on the bus.

Each channel raises its status bit with an event pulse. Software clears status bits by writing ones to them. When it does, the block sends a clear strobe to each channel whose bit was actually set. The channel count `NUM_CH` may be set from 3 to 32. The window only has room for 24 channel groups, so any channel index at or above the smaller of 24 and `NUM_CH` decodes as invalid.

Top module: `evt_timer_globals`

## Requirements
- R1: After reset the main counter, the configuration bits, every status bit and the read-data register are all zero.
- R2: The capability word at offset 0x00 reads revision 1 in bits 7:0, NUM_CH-1 in bits 12:8, 1 in bit 13 (64-bit counter), 0 in bit 14, 1 in bit 15 (legacy routing capable), the vendor parameter in bits 31:16 and the tick period in femtoseconds in bits 63:32 (default 10,000,000). Writes to it leave it unchanged.
- R3: In the configuration word at offset 0x10, only bit 0 (enable) and bit 1 (legacy route) are writable. All other bits read 0. The two bits are driven on `glb_enable` and `glb_legacy`, and they change only on a write to the lower half.
- R4: While enabled, the main counter increases by exactly 1 on each cycle with `tick_en` high, carrying from the lower half into the upper half. While disabled it holds, and on re-enable it continues from the held value.
- R5: The counter at offset 0xF0 is read and written in two 32-bit halves, where address bit 2 = 1 selects bits 63:32. A half write replaces only that half, and it takes priority over a tick in the same cycle.
- R6: A write to the lower half of the status word at offset 0x20 clears each status bit that is set and written as 1. Bits written as 0 are unaffected. During the access cycle, `ch_clear` equals the written ones ANDed with the set bits.
- R7: An `ch_event` pulse sets that channel's status bit one cycle later. If the bit is set and cleared in the same cycle, the set wins.
- R8: An address 0x100 + n*0x20 + r, with n < NUM_CH and r in {0x00, 0x08, 0x10}, asserts `ch_sel[n]` only, with `ch_reg` = r/8 (0 config, 1 comparator, 2 route) and `ch_hi` = address bit 2. `ch_we` is high for a write. An index at or above NUM_CH, or r = 0x18, selects nothing.
- R9: Unknown addresses, including invalid channel addresses, read as zero. Writes to them change no state.
- R10: `bus_rdata` is loaded at the clock edge that ends a read access, and it holds its value at every other edge.
- R11: A read of a valid channel address returns that channel's 32-bit word from `ch_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address in the window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| tick_en | input | 1 | Main counter tick strobe |
| ch_event | input | NUM_CH | Per-channel status set pulses |
| ch_rdata | input | NUM_CH*32 | Per-channel read words, channel i in bits 32i+31:32i |
| ch_sel | output | NUM_CH | One-hot channel register select |
| ch_reg | output | 2 | Channel register code |
| ch_hi | output | 1 | Upper-half select for the channel access |
| ch_we | output | 1 | Channel write strobe |
| ch_clear | output | NUM_CH | Per-channel status clear strobes |
| main_count | output | 64 | Main counter value |
| glb_enable | output | 1 | Overall enable bit |
| glb_legacy | output | 1 | Legacy routing bit |

## Verification
A wrong counter state appears on `main_count` at the very next edge: a missed tick, an extra tick or a lost carry shows up as an off-by-one value or as a wrong upper half. A corrupted status or configuration bit is caught on the next read or on the next `glb_*` comparison. A wrong clear shows up in the same cycle as a `ch_clear` pattern that differs from the written ones ANDed with the set bits. Decode errors show up in the same cycle as a wrong one-hot `ch_sel`, and they show up one cycle later as a non-zero read from a hole in the window.

// File: rtl/evt_pkg.sv
// Shared types and window constants for the event timer global block.
// Assumes a 10-bit byte address and a 32-bit data bus.
package evt_pkg;
    localparam int ADDR_W   = 10;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 64;
    localparam int IDX_W    = 5;
    localparam int TREG_W   = 2;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_CFG,
        SEL_STAT,
        SEL_CNT,
        SEL_TMR
    } sel_e;

    typedef struct packed {
        sel_e              kind;
        logic              hi;
        logic [IDX_W-1:0]  idx;
        logic [TREG_W-1:0] treg;
    } dec_t;
endpackage

// File: rtl/evt_addr_decode.sv
// Address decoder: classifies a window address as a global register,
// a channel register or a hole. Purely combinational.
// Assumes word-aligned addresses; bits 1:0 are ignored.
module evt_addr_decode
    import evt_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int GRP_BASE = 8;  // 0x100 >> 5

    logic [IDX_W-1:0] tidx;

    // Channel index relative to the first channel group.
    always_comb tidx = addr[9:5] - IDX_W'(GRP_BASE);

    // Classify the address.
    always_comb begin
        dec      = '0;
        dec.kind = SEL_NONE;
        dec.hi   = addr[2];
        dec.idx  = tidx;
        dec.treg = addr[4:3];
        if (addr[9:8] == 2'b00) begin
            case (addr[7:3])
                5'h00:   dec.kind = SEL_CAP;
                5'h02:   dec.kind = SEL_CFG;
                5'h04:   dec.kind = SEL_STAT;
                5'h1E:   dec.kind = SEL_CNT;
                default: dec.kind = SEL_NONE;
            endcase
        end else if (({1'b0, tidx} < 6'(NUM_CH)) && (addr[4:3] != 2'b11)) begin
            dec.kind = SEL_TMR;
        end
    end
endmodule

// File: rtl/evt_main_counter.sv
// 64-bit main counter with 32-bit half writes.
// Assumes the caller never asserts both half writes in one cycle.
module evt_main_counter #(
    parameter int CNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wdata,
    output logic [CNT_W-1:0]   count
);
    localparam int HALF = CNT_W / 2;

    // Half writes take priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (wr_lo) count[HALF-1:0] <= wdata;
        else if (wr_hi) count[CNT_W-1:HALF] <= wdata;
        else if (run)   count <= count + CNT_W'(1);
    end

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'(1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_lo && !wr_hi) |=> $stable(count));

    assert_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[CNT_W-1:HALF] == $past(count[CNT_W-1:HALF]));
endmodule

// File: rtl/evt_int_status.sv
// Per-channel interrupt status: set by channel pulses, cleared by
// write-one-to-clear; emits clear strobes for bits actually cleared.
module evt_int_status #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_data,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] clr_strobe
);
    // Only bits that are currently set are cleared.
    always_comb clr_strobe = clr_wr ? (clr_data & status) : '0;

    // Update the status bits; a set in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_strobe) | set;
    end

    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (status & $past(clr_data & ~set)) == '0);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> (status & $past(set)) == $past(set));

    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> (status & $past(status)) == $past(status));
endmodule

// File: rtl/evt_timer_globals.sv
// Global register block of a multi-channel event timer: capability,
// configuration, interrupt status and main counter, plus channel select
// forwarding. Assumes 3 <= NUM_CH <= 32 and a single-cycle register bus.
module evt_timer_globals
    import evt_pkg::*;
#(
    parameter int          NUM_CH  = 3,
    parameter logic [15:0] VENDOR  = 16'h5A3C,
    parameter logic [31:0] TICK_FS = 32'd10_000_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic                     tick_en,
    input  logic [NUM_CH-1:0]        ch_event,
    input  logic [NUM_CH*WORD_W-1:0] ch_rdata,
    output logic [NUM_CH-1:0]        ch_sel,
    output logic [TREG_W-1:0]        ch_reg,
    output logic                     ch_hi,
    output logic                     ch_we,
    output logic [NUM_CH-1:0]        ch_clear,
    output logic [CNT_W-1:0]         main_count,
    output logic                     glb_enable,
    output logic                     glb_legacy
);
    localparam logic [7:0]  REV_ID = 8'h01;
    localparam logic [CNT_W-1:0] CAP_WORD =
        {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b1, 5'(NUM_CH - 1), REV_ID};

    dec_t              dec;
    logic              acc_wr, acc_rd;
    logic              cfg_wr, stat_wr, cnt_wr_lo, cnt_wr_hi;
    logic [1:0]        cfg_q;
    logic [NUM_CH-1:0] status;
    logic [CNT_W-1:0]  reg_val;
    logic [WORD_W-1:0] ch_word, rd_word;

    evt_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    // Access qualifiers per register.
    always_comb begin
        acc_wr    = bus_valid && bus_write;
        acc_rd    = bus_valid && !bus_write;
        cfg_wr    = acc_wr && dec.kind == SEL_CFG  && !dec.hi;
        stat_wr   = acc_wr && dec.kind == SEL_STAT && !dec.hi;
        cnt_wr_lo = acc_wr && dec.kind == SEL_CNT  && !dec.hi;
        cnt_wr_hi = acc_wr && dec.kind == SEL_CNT  &&  dec.hi;
    end

    // Configuration: only enable and legacy bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= bus_wdata[1:0];
    end

    assign glb_enable = cfg_q[0];
    assign glb_legacy = cfg_q[1];

    evt_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q[0] && tick_en),
        .wr_lo (cnt_wr_lo),
        .wr_hi (cnt_wr_hi),
        .wdata (bus_wdata),
        .count (main_count)
    );

    evt_int_status #(.NUM_CH(NUM_CH)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (ch_event),
        .clr_wr     (stat_wr),
        .clr_data   (bus_wdata[NUM_CH-1:0]),
        .status     (status),
        .clr_strobe (ch_clear)
    );

    // One-hot channel select per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign ch_sel[g] = bus_valid && dec.kind == SEL_TMR && dec.idx == IDX_W'(g);
    end

    assign ch_reg = dec.treg;
    assign ch_hi  = dec.hi;
    assign ch_we  = acc_wr && dec.kind == SEL_TMR;

    // Gather the selected channel's read word.
    always_comb begin
        ch_word = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_sel[i]) ch_word |= ch_rdata[i*WORD_W +: WORD_W];
    end

    // Select the 64-bit global register being read.
    always_comb begin
        case (dec.kind)
            SEL_CAP:  reg_val = CAP_WORD;
            SEL_CFG:  reg_val = CNT_W'(cfg_q);
            SEL_STAT: reg_val = CNT_W'(status);
            SEL_CNT:  reg_val = main_count;
            default:  reg_val = '0;
        endcase
        if (dec.kind == SEL_TMR) rd_word = ch_word;
        else rd_word = dec.hi ? reg_val[CNT_W-1:WORD_W] : reg_val[WORD_W-1:0];
    end

    // Read data register, loaded only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (acc_rd) bus_rdata <= rd_word;
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (main_count == '0 && cfg_q == '0 && bus_rdata == '0));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable({glb_enable, glb_legacy}));

    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_sel));

    assert_sel_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> ch_sel == '0);

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> $stable(bus_rdata));
endmodule

// File: tb/evt_timer_globals_bench.sv
// Bench: behavioural reference model compared every cycle.
module evt_timer_globals_bench;
    localparam int NC = 3;
    localparam logic [15:0] VEND = 16'h5A3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 0, bus_write = 0, tick_en = 0;
    logic [9:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] ch_event = '0;
    logic [NC*32-1:0] ch_rdata;
    logic [NC-1:0] ch_sel, ch_clear;
    logic [1:0] ch_reg;
    logic ch_hi, ch_we;
    logic [63:0] main_count;
    logic glb_enable, glb_legacy;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R1";

    // Model state
    logic [63:0] m_cnt = '0;
    logic [1:0]  m_cfg = '0;
    logic [NC-1:0] m_stat = '0;
    logic [31:0] m_rd = '0;

    always #10 clk = ~clk;

    always_comb
        for (int i = 0; i < NC; i++) ch_rdata[i*32 +: 32] = 32'hA500_0000 + 32'(i);

    evt_timer_globals #(.NUM_CH(NC), .VENDOR(VEND)) u_evt_timer_globals (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .ch_event(ch_event), .ch_rdata(ch_rdata),
        .ch_sel(ch_sel), .ch_reg(ch_reg), .ch_hi(ch_hi), .ch_we(ch_we),
        .ch_clear(ch_clear), .main_count(main_count),
        .glb_enable(glb_enable), .glb_legacy(glb_legacy));

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int tmr_idx(input logic [9:0] a);
        return (int'(a) - 32'h100) >> 5;
    endfunction

    function automatic bit tmr_ok(input logic [9:0] a);
        return a >= 10'h100 && tmr_idx(a) < NC && a[4:3] != 2'b11;
    endfunction

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        logic [63:0] v;
        logic [63:0] cap;
        cap = {32'd10_000_000, VEND, 1'b1, 1'b0, 1'b1, 5'(NC - 1), 8'h01};
        if (a < 10'h100) begin
            case ({a[7:3], 3'b000})
                8'h00:   v = cap;
                8'h10:   v = 64'(m_cfg);
                8'h20:   v = 64'(m_stat);
                8'hF0:   v = m_cnt;
                default: v = '0;
            endcase
            return a[2] ? v[63:32] : v[31:0];
        end
        if (tmr_ok(a)) return 32'hA500_0000 + 32'(tmr_idx(a));
        return '0;
    endfunction

    task automatic cyc(input bit v, input bit w, input logic [9:0] a, input logic [31:0] d,
                       input bit tk, input logic [NC-1:0] ev);
        logic [NC-1:0] e_sel, e_clr;
        bit stw;
        @(negedge clk);
        chk("R4", "main_count", main_count, m_cnt);
        chk("R3", "glb bits", 64'({glb_legacy, glb_enable}), 64'(m_cfg));
        chk(cur_tag, "bus_rdata", 64'(bus_rdata), 64'(m_rd));
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; tick_en = tk; ch_event = ev;
        #1;
        e_sel = '0;
        if (v && tmr_ok(a)) e_sel[tmr_idx(a)] = 1'b1;
        stw = v && w && a == 10'h020;
        e_clr = stw ? (d[NC-1:0] & m_stat) : '0;
        chk("R8", "ch_sel", 64'(ch_sel), 64'(e_sel));
        chk("R8", "ch_we", 64'(ch_we), 64'(v && w && e_sel != 0));
        if (e_sel != 0) begin
            chk("R8", "ch_reg", 64'(ch_reg), 64'(a[4:3]));
            chk("R8", "ch_hi", 64'(ch_hi), 64'(a[2]));
        end
        chk("R6", "ch_clear", 64'(ch_clear), 64'(e_clr));
        // Model next state
        if (v && !w) m_rd = exp_read(a);
        if (v && w && a == 10'h0F0) m_cnt[31:0] = d;
        else if (v && w && a == 10'h0F4) m_cnt[63:32] = d;
        else if (m_cfg[0] && tk) m_cnt = m_cnt + 64'd1;
        m_stat = (m_stat & ~e_clr) | ev;
        if (v && w && a == 10'h010) m_cfg = d[1:0];
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        cyc(1, 1, a, d, 0, '0);
    endtask

    task automatic rd(input logic [9:0] a);
        cyc(1, 0, a, '0, 0, '0);
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, tk, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        cur_tag = "R1";
        idle(1, 1);
        rd(10'h0F0); rd(10'h0F4); rd(10'h010); rd(10'h020);
        // R2: capability and read-only
        cur_tag = "R2";
        rd(10'h000); rd(10'h004);
        wr(10'h000, 32'hFFFF_FFFF); wr(10'h004, 32'h0);
        rd(10'h000); rd(10'h004);
        // R3: config mask
        cur_tag = "R3";
        wr(10'h010, 32'hFFFF_FFFE); rd(10'h010); rd(10'h014);
        wr(10'h014, 32'hFFFF_FFFF); rd(10'h010);
        wr(10'h010, 32'h0); rd(10'h010);
        // R5: halted half writes, tick ignored
        cur_tag = "R5";
        wr(10'h0F0, 32'hFFFF_FFFE); wr(10'h0F4, 32'h0000_0001);
        idle(3, 1);
        rd(10'h0F0); rd(10'h0F4);
        // R4: enable and count across the carry
        cur_tag = "R4";
        cyc(1, 1, 10'h010, 32'h1, 1, '0);
        idle(4, 1);
        for (int i = 0; i < 6; i++) cyc(0, 0, '0, '0, i[0], '0);
        rd(10'h0F4); rd(10'h0F0);
        wr(10'h010, 32'h0); idle(4, 1);
        wr(10'h010, 32'h3); idle(3, 1);
        wr(10'h010, 32'h0);
        // R5: half write wins over tick
        cur_tag = "R5";
        wr(10'h010, 32'h1);
        cyc(1, 1, 10'h0F0, 32'h0000_0100, 1, '0);
        idle(2, 1); rd(10'h0F0);
        wr(10'h010, 32'h0);
        // R6 / R7: status
        cur_tag = "R6";
        cyc(0, 0, '0, '0, 0, 3'b011);
        rd(10'h020);
        wr(10'h020, 32'h0000_0006); rd(10'h020);
        wr(10'h020, 32'h0000_0004); rd(10'h020);
        wr(10'h024, 32'hFFFF_FFFF); rd(10'h020);
        cur_tag = "R7";
        cyc(1, 1, 10'h020, 32'h1, 0, 3'b001);
        rd(10'h020);
        cyc(0, 0, '0, '0, 0, 3'b100);
        wr(10'h020, 32'h7); rd(10'h020);
        // R8 / R11: channel decode and read words
        cur_tag = "R11";
        rd(10'h100); rd(10'h12C); rd(10'h150); rd(10'h148);
        wr(10'h108, 32'h1234_5678); wr(10'h154, 32'h1);
        // R9: holes
        cur_tag = "R9";
        rd(10'h160); rd(10'h118); rd(10'h3F0);
        wr(10'h018, 32'h3); rd(10'h018); rd(10'h010);
        rd(10'h030); rd(10'h0F8); wr(10'h0F8, 32'hFFFF_FFFF); rd(10'h0F0);
        // R10: rdata holds across writes and idles
        cur_tag = "R10";
        rd(10'h004); wr(10'h010, 32'h0); idle(2, 0);
        idle(1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule